// File: doc/BRIEF.md
# Reorder Buffer Retirement Stage with Deferred Faults

This block holds the in-flight instructions of an out-of-order core in program order and retires them. Dispatch allocates one entry per cycle and receives a tag for it. Execution units later report completion against that tag, together with the result and a fault flag. Every cycle the block looks at a fixed window of the oldest entries, three by default. It retires the finished ones in order and stops at the first entry that has not finished.

A retiring entry either drives one of the architectural register write ports or pulses a store release toward memory. A fault is not raised when an execution unit reports it. It stays in the entry until that entry is the oldest one left in the window. At that point the block raises a flush for one cycle, drives the fault handler address as the redirect PC, and reports the faulting PC. Older entries in the same window still retire. The faulting entry and everything younger are discarded, and the buffer is empty on the next cycle.

Top module: `rob_retire`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, no write enable, store release or flush is active, and idle write ports carry address and data 0.
- R2: Allocations receive consecutive tags modulo DEPTH. While DEPTH entries are held, `alloc_ready` is 0 and an allocation request is ignored, so it does not move the tag handed to the next allocation.
- R3: Up to WIDTH (3) of the oldest finished entries retire in the same cycle, with slot k carrying the k-th oldest. Finished entries beyond the window retire on the following cycles.
- R4: The scan stops at the oldest unfinished entry. Younger finished entries do not retire until it finishes.
- R5: A retiring non-store entry sets `arf_we[k]` and drives its destination and result on port k. A retiring store sets `st_release[k]` and drives its tag on slice k of `st_tag`, with no register write.
- R6: A fault reported at writeback is not signalled at that time. `flush` stays 0 while any older entry is unfinished.
- R7: When a faulted entry is reached by the scan, `flush` is 1 for exactly that cycle, `flush_pc` equals HANDLER_PC and `fault_epc` equals the entry's PC.
- R8: In the cycle of a flush, entries older than the faulted one in the window retire normally. The faulted entry and younger entries produce no write or store release.
- R9: In the flush cycle `alloc_ready` is 0. On the next cycle the buffer is empty, `alloc_ready` is 1 and `alloc_tag` is the position just after the last retired entry.
- R10: A fault recorded in an entry younger than the trapping one is never signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a new entry |
| alloc_store | input | 1 | New entry is a store |
| alloc_dest | input | AREG_W | Architectural destination register of the new entry |
| alloc_pc | input | PC_W | PC of the new entry |
| alloc_ready | output | 1 | An entry can be allocated this cycle |
| alloc_tag | output | TAG_W | Tag given to the entry allocated this cycle |
| wb_valid | input | 1 | Execution completion report |
| wb_tag | input | TAG_W | Tag of the completed entry |
| wb_data | input | XLEN | Result value |
| wb_fault | input | 1 | Execution detected a fault |
| arf_we | output | WIDTH | Register write enable per retire slot |
| arf_waddr | output | WIDTH*AREG_W | Register address per slot, slot k at bits k*AREG_W |
| arf_wdata | output | WIDTH*XLEN | Register data per slot, slot k at bits k*XLEN |
| st_release | output | WIDTH | Store release pulse per slot |
| st_tag | output | WIDTH*TAG_W | Tag of the released store per slot |
| flush | output | 1 | Pipeline flush for a fault reaching retirement |
| flush_pc | output | PC_W | Redirect target (fault handler) |
| fault_epc | output | PC_W | PC of the faulting entry |

## Verification
Completions are reported out of program order. Reverse-order completion of a group of five checks that retirement is split across the width limit in two cycles. A gap left by one unfinished entry checks that the scan stops there and does not skip over it. A mixed group with a store in the middle checks port selection and that the store release never writes a register.

Two fault patterns are tried. In the first, a faulted entry sits behind unfinished ones, with a second faulted entry younger than it. This separates deferral, partial retirement of older entries and suppression of wrong-path faults. In the second, a fault sits at the head with a finished younger entry behind it. A final fill to capacity across the tag wrap checks the full stall and that a refused allocation leaves no trace in the tags.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Outcome of one retire slot in the current cycle.
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_RETIRE = 2'd1,
      ACT_TRAP   = 2'd2
   } slot_act_t;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store #(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 3,
   parameter int XLEN   = 32,
   parameter int AREG_W = 5,
   parameter int PC_W   = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              alloc_en,
   input  logic [$clog2(DEPTH)-1:0]          alloc_idx,
   input  logic                              alloc_store,
   input  logic [AREG_W-1:0]                 alloc_dest,
   input  logic [PC_W-1:0]                   alloc_pc,
   input  logic                              wb_en,
   input  logic [$clog2(DEPTH)-1:0]          wb_idx,
   input  logic [XLEN-1:0]                   wb_data,
   input  logic                              wb_fault,
   input  logic [$clog2(DEPTH)-1:0]          head,
   output logic [WIDTH-1:0]                  rd_done,
   output logic [WIDTH-1:0]                  rd_fault,
   output logic [WIDTH-1:0]                  rd_store,
   output logic [WIDTH-1:0][AREG_W-1:0]      rd_dest,
   output logic [WIDTH-1:0][XLEN-1:0]        rd_data,
   output logic [WIDTH-1:0][PC_W-1:0]        rd_pc
);
   localparam int TAG_W = $clog2(DEPTH);

   logic [DEPTH-1:0]  done_q;
   logic [DEPTH-1:0]  fault_q;
   logic [DEPTH-1:0]  store_q;
   logic [AREG_W-1:0] dest_q [DEPTH];
   logic [XLEN-1:0]   data_q [DEPTH];
   logic [PC_W-1:0]   pc_q   [DEPTH];

   // Status flags: allocation clears, writeback sets.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= '0;
         fault_q <= '0;
         store_q <= '0;
      end else begin
         if (alloc_en) begin
            done_q[alloc_idx]  <= 1'b0;
            fault_q[alloc_idx] <= 1'b0;
            store_q[alloc_idx] <= alloc_store;
         end
         if (wb_en) begin
            done_q[wb_idx]  <= 1'b1;
            fault_q[wb_idx] <= wb_fault;
         end
      end
   end

   // Payload storage needs no reset: only live entries are ever read.
   always_ff @(posedge clk) begin
      if (alloc_en) begin
         dest_q[alloc_idx] <= alloc_dest;
         pc_q[alloc_idx]   <= alloc_pc;
      end
      if (wb_en) begin
         data_q[wb_idx] <= wb_data;
      end
   end

   // One read port per retire slot, at head + slot (wraps: DEPTH is 2^n).
   for (genvar s = 0; s < WIDTH; s++) begin : g_rd
      logic [TAG_W-1:0] idx;
      assign idx         = head + TAG_W'(s);
      assign rd_done[s]  = done_q[idx];
      assign rd_fault[s] = fault_q[idx];
      assign rd_store[s] = store_q[idx];
      assign rd_dest[s]  = dest_q[idx];
      assign rd_data[s]  = data_q[idx];
      assign rd_pc[s]    = pc_q[idx];
   end

endmodule

// File: rtl/rob_commit_scan.sv
module rob_commit_scan #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 3
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [$clog2(DEPTH+1)-1:0]                 live_cnt,
   input  logic [WIDTH-1:0]                           rd_done,
   input  logic [WIDTH-1:0]                           rd_fault,
   output rob_pkg::slot_act_t [WIDTH-1:0]             act,
   output logic [$clog2(WIDTH+1)-1:0]                 n_retire,
   output logic                                       trap,
   output logic [rob_pkg::bits_for(WIDTH)-1:0]        trap_slot
);
   import rob_pkg::*;

   localparam int CW_W   = $clog2(WIDTH+1);
   localparam int SLOT_W = bits_for(WIDTH);

   logic [WIDTH:0]   reach;
   logic [WIDTH-1:0] trap_vec;

   assign reach[0] = 1'b1;

   // Ripple chain: slot k is looked at only if every older slot retired.
   for (genvar s = 0; s < WIDTH; s++) begin : g_slot
      logic live, ready;
      assign live         = (s < int'(live_cnt));
      assign ready        = reach[s] & live & rd_done[s];
      assign act[s]       = !ready      ? ACT_HOLD :
                            rd_fault[s] ? ACT_TRAP : ACT_RETIRE;
      assign trap_vec[s]  = ready & rd_fault[s];
      assign reach[s+1]   = ready & ~rd_fault[s];
   end

   always_comb begin
      n_retire  = '0;
      trap      = 1'b0;
      trap_slot = '0;
      for (int s = 0; s < WIDTH; s++) begin
         if (act[s] == ACT_RETIRE) n_retire = n_retire + CW_W'(1);
         if (act[s] == ACT_TRAP) begin
            trap      = 1'b1;
            trap_slot = SLOT_W'(s);
         end
      end
   end

   AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(trap_vec) <= 1); // R7

   AST_TRAP_AFTER_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (32'(n_retire) == 32'(trap_slot))); // R8

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_fire,
   input  logic [$clog2(WIDTH+1)-1:0]   n_retire,
   input  logic                         trap,
   output logic [$clog2(DEPTH)-1:0]     head,
   output logic [$clog2(DEPTH)-1:0]     tail,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int TAG_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [TAG_W-1:0] head_n;
   assign head_n = head + TAG_W'(n_retire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head <= head_n;
         if (trap) begin
            tail  <= head_n;
            count <= '0;
         end else begin
            tail  <= tail + TAG_W'(alloc_fire);
            count <= count - CNT_W'(n_retire) + CNT_W'(alloc_fire);
         end
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R2

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> (count == '0)); // R9

   AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      TAG_W'(tail - head) == TAG_W'(count)); // R2

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
   parameter int              DEPTH       = 16,
   parameter int              WIDTH       = 3,
   parameter int              XLEN        = 32,
   parameter int              AREG_W      = 5,
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] HANDLER_PC  = 'h100,
   parameter bit              QUIET_PORTS = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_valid,
   input  logic                      alloc_store,
   input  logic [AREG_W-1:0]         alloc_dest,
   input  logic [PC_W-1:0]           alloc_pc,
   output logic                      alloc_ready,
   output logic [$clog2(DEPTH)-1:0]  alloc_tag,
   input  logic                      wb_valid,
   input  logic [$clog2(DEPTH)-1:0]  wb_tag,
   input  logic [XLEN-1:0]           wb_data,
   input  logic                      wb_fault,
   output logic [WIDTH-1:0]          arf_we,
   output logic [WIDTH*AREG_W-1:0]   arf_waddr,
   output logic [WIDTH*XLEN-1:0]     arf_wdata,
   output logic [WIDTH-1:0]          st_release,
   output logic [WIDTH*$clog2(DEPTH)-1:0] st_tag,
   output logic                      flush,
   output logic [PC_W-1:0]           flush_pc,
   output logic [PC_W-1:0]           fault_epc
);
   import rob_pkg::*;

   localparam int TAG_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH+1);
   localparam int CW_W   = $clog2(WIDTH+1);
   localparam int SLOT_W = bits_for(WIDTH);

   // Elaboration-time parameter checks.
   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("rob_retire: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1 || WIDTH > DEPTH) begin : g_bad_width
      $error("rob_retire: WIDTH must lie in 1..DEPTH");
   end

   logic [TAG_W-1:0]             head, tail;
   logic [CNT_W-1:0]             count;
   logic [WIDTH-1:0]             rd_done, rd_fault, rd_store;
   logic [WIDTH-1:0][AREG_W-1:0] rd_dest;
   logic [WIDTH-1:0][XLEN-1:0]   rd_data;
   logic [WIDTH-1:0][PC_W-1:0]   rd_pc;
   slot_act_t [WIDTH-1:0]        act;
   logic [CW_W-1:0]              n_retire;
   logic                         trap;
   logic [SLOT_W-1:0]            trap_slot;
   logic                         alloc_fire;
   logic [TAG_W-1:0]             wb_off;
   logic                         wb_live;

   assign alloc_ready = (count != CNT_W'(DEPTH)) && !trap;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_tag   = tail;

   // Writebacks to dead slots (wrong path or flushed) are dropped.
   assign wb_off  = wb_tag - head;
   assign wb_live = wb_valid && (CNT_W'(wb_off) < count) && !trap;

   rob_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .XLEN(XLEN),
               .AREG_W(AREG_W), .PC_W(PC_W)) u_store (
      .clk, .rst_n,
      .alloc_en(alloc_fire), .alloc_idx(tail), .alloc_store, .alloc_dest,
      .alloc_pc, .wb_en(wb_live), .wb_idx(wb_tag), .wb_data, .wb_fault,
      .head, .rd_done, .rd_fault, .rd_store, .rd_dest, .rd_data, .rd_pc
   );

   rob_commit_scan #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_scan (
      .clk, .rst_n, .live_cnt(count), .rd_done, .rd_fault,
      .act, .n_retire, .trap, .trap_slot
   );

   rob_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
      .clk, .rst_n, .alloc_fire, .n_retire, .trap, .head, .tail, .count
   );

   for (genvar s = 0; s < WIDTH; s++) begin : g_port
      logic retire;
      assign retire        = (act[s] == ACT_RETIRE);
      assign arf_we[s]     = retire & ~rd_store[s];
      assign st_release[s] = retire &  rd_store[s];
      if (QUIET_PORTS) begin : g_quiet
         assign arf_waddr[s*AREG_W +: AREG_W] = arf_we[s] ? rd_dest[s] : '0;
         assign arf_wdata[s*XLEN +: XLEN]     = arf_we[s] ? rd_data[s] : '0;
         assign st_tag[s*TAG_W +: TAG_W]      = st_release[s] ? TAG_W'(head + TAG_W'(s)) : '0;
      end else begin : g_raw
         assign arf_waddr[s*AREG_W +: AREG_W] = rd_dest[s];
         assign arf_wdata[s*XLEN +: XLEN]     = rd_data[s];
         assign st_tag[s*TAG_W +: TAG_W]      = TAG_W'(head + TAG_W'(s));
      end
      if (s > 0) begin : g_order
         AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (arf_we[s] | st_release[s]) |-> (arf_we[s-1] | st_release[s-1])); // R4
      end
   end

   assign flush     = trap;
   assign flush_pc  = HANDLER_PC;
   assign fault_epc = trap ? rd_pc[trap_slot] : '0;

   AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !alloc_ready); // R2

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush); // R7

   AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready); // R9

endmodule

// File: tb/rob_retire_test.sv
module rob_retire_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 8;
   localparam int WIDTH  = 3;
   localparam int XLEN   = 32;
   localparam int AREG_W = 5;
   localparam int PC_W   = 32;
   localparam int TAG_W  = 3;
   localparam logic [PC_W-1:0] HPC = 32'h0000_0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0, alloc_store = 1'b0;
   logic [AREG_W-1:0] alloc_dest = '0;
   logic [PC_W-1:0]   alloc_pc = '0;
   logic alloc_ready;
   logic [TAG_W-1:0] alloc_tag;
   logic wb_valid = 1'b0, wb_fault = 1'b0;
   logic [TAG_W-1:0] wb_tag = '0;
   logic [XLEN-1:0] wb_data = '0;
   logic [WIDTH-1:0] arf_we, st_release;
   logic [WIDTH*AREG_W-1:0] arf_waddr;
   logic [WIDTH*XLEN-1:0] arf_wdata;
   logic [WIDTH*TAG_W-1:0] st_tag;
   logic flush;
   logic [PC_W-1:0] flush_pc, fault_epc;

   always #(CLK_PERIOD/2) clk = ~clk;

   rob_retire #(.DEPTH(DEPTH), .WIDTH(WIDTH), .XLEN(XLEN), .AREG_W(AREG_W),
                .PC_W(PC_W), .HANDLER_PC(HPC)) uut (
      .clk, .rst_n, .alloc_valid, .alloc_store, .alloc_dest, .alloc_pc,
      .alloc_ready, .alloc_tag, .wb_valid, .wb_tag, .wb_data, .wb_fault,
      .arf_we, .arf_waddr, .arf_wdata, .st_release, .st_tag,
      .flush, .flush_pc, .fault_epc
   );

   typedef struct {
      int         slot;
      bit         st;
      int         addr;
      logic [31:0] data;
      int         tag;
   } item_t;

   item_t       exp_q[$];
   logic [31:0] flush_q[$];
   int errors = 0;
   int checks = 0;
   int exp_head = 0;
   int exp_tail = 0;
   int last_tag = 0;
   bit          m_st   [DEPTH];
   int          m_dest [DEPTH];
   logic [31:0] m_data [DEPTH];
   logic [31:0] m_pc   [DEPTH];
   bit done_flag = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Drivers: called just after a rising edge, return just after the next one.
   task automatic alloc_one(input bit st, input int dest, input logic [31:0] pc);
      int t;
      t = exp_tail % DEPTH;
      alloc_valid = 1'b1; alloc_store = st;
      alloc_dest = AREG_W'(dest); alloc_pc = pc;
      #2;
      check(alloc_ready == 1'b1, "R2", "alloc_ready before alloc", alloc_ready, 1);
      check(int'(alloc_tag) == t, "R2", "alloc_tag", alloc_tag, t);
      m_st[t] = st; m_dest[t] = dest; m_pc[t] = pc; m_data[t] = '0;
      last_tag = t;
      exp_tail++;
      @(posedge clk); #1;
      alloc_valid = 1'b0; alloc_store = 1'b0;
   endtask

   task automatic wb_one(input int tag, input logic [31:0] d, input bit f);
      wb_valid = 1'b1; wb_tag = TAG_W'(tag); wb_data = d; wb_fault = f;
      m_data[tag] = d;
      @(posedge clk); #1;
      wb_valid = 1'b0; wb_fault = 1'b0;
   endtask

   task automatic expect_retire(input int slot, input int tag);
      item_t it;
      it.slot = slot; it.st = m_st[tag]; it.addr = m_dest[tag];
      it.data = m_data[tag]; it.tag = tag;
      exp_q.push_back(it);
      exp_head++;
   endtask

   task automatic expect_trap(input int tag);
      flush_q.push_back(m_pc[tag]);
   endtask

   task automatic peek();
      @(negedge clk);
   endtask

   task automatic resume();
      @(posedge clk); #1;
   endtask

   // Monitor: compares every retire slot and flush against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         for (int i = 0; i < WIDTH; i++) begin
            if (arf_we[i] || st_release[i]) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", "unexpected retire on slot", i, -1);
               end else begin
                  item_t it;
                  it = exp_q.pop_front();
                  check(it.slot == i, "R3", "retire slot", i, it.slot);
                  check(st_release[i] == it.st, "R5", "store vs register", st_release[i], it.st);
                  if (it.st) begin
                     check(int'(st_tag[i*TAG_W +: TAG_W]) == it.tag, "R5", "store tag",
                           st_tag[i*TAG_W +: TAG_W], it.tag);
                  end else begin
                     check(int'(arf_waddr[i*AREG_W +: AREG_W]) == it.addr, "R5", "write address",
                           arf_waddr[i*AREG_W +: AREG_W], it.addr);
                     check(arf_wdata[i*XLEN +: XLEN] == it.data, "R5", "write data",
                           arf_wdata[i*XLEN +: XLEN], it.data);
                  end
               end
            end
         end
         if (flush) begin
            if (flush_q.size() == 0) begin
               check(1'b0, "R10", "unexpected flush epc", fault_epc, 0);
            end else begin
               logic [31:0] e;
               e = flush_q.pop_front();
               check(fault_epc == e, "R7", "fault_epc", fault_epc, e);
               check(flush_pc == HPC, "R7", "flush_pc", flush_pc, HPC);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
   end

   initial begin
      int t0, t1, t2;
      int a [5];
      int f [8];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      peek();
      check(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
      check(alloc_tag == '0, "R1", "alloc_tag", alloc_tag, 0);
      check(arf_we == '0 && st_release == '0, "R1", "retire idle", {arf_we, st_release}, 0);
      check(flush == 1'b0, "R1", "flush", flush, 0);
      check(arf_waddr == '0 && arf_wdata == '0, "R1", "idle ports zero", arf_wdata, 0);
      resume();

      // R3/R4: out-of-order completion, all three retire together
      alloc_one(0, 1, 32'h1000); t0 = last_tag;
      alloc_one(0, 2, 32'h1004); t1 = last_tag;
      alloc_one(0, 3, 32'h1008); t2 = last_tag;
      wb_one(t2, 32'hA2, 0);
      wb_one(t1, 32'hA1, 0);
      peek();
      check(arf_we == 3'b000, "R4", "held behind unfinished head", arf_we, 0);
      resume();
      wb_one(t0, 32'hA0, 0);
      expect_retire(0, t0); expect_retire(1, t1); expect_retire(2, t2);
      peek();
      check(arf_we == 3'b111, "R3", "three retire in one cycle", arf_we, 3'b111);
      resume();

      // R3/R5: five finished entries split 3+2, one store, tags wrap
      for (int k = 0; k < 5; k++) begin
         alloc_one(k == 3, 8 + k, 32'h2000 + 32'(4*k));
         a[k] = last_tag;
      end
      for (int k = 4; k >= 0; k--) wb_one(a[k], 32'hB0 + 32'(k), 0);
      for (int k = 0; k < 5; k++) expect_retire(k % 3, a[k]);
      peek();
      check(arf_we == 3'b111, "R3", "first batch of window", arf_we, 3'b111);
      resume();
      peek();
      check(st_release == 3'b001, "R5", "store release slot 0", st_release, 3'b001);
      check(arf_we == 3'b010, "R5", "store slot makes no write", arf_we, 3'b010);
      resume();

      // R4: gap in the middle stops the scan
      alloc_one(0, 4, 32'h3000); t0 = last_tag;
      alloc_one(0, 5, 32'h3004); t1 = last_tag;
      alloc_one(0, 6, 32'h3008); t2 = last_tag;
      wb_one(t2, 32'hC2, 0);
      wb_one(t0, 32'hC0, 0);
      expect_retire(0, t0);
      peek();
      check(arf_we == 3'b001, "R4", "only the head retires", arf_we, 3'b001);
      resume();
      peek();
      check(arf_we == 3'b000, "R4", "finished entry waits behind gap", arf_we, 0);
      resume();
      wb_one(t1, 32'hC1, 0);
      expect_retire(0, t1); expect_retire(1, t2);
      peek();
      check(arf_we == 3'b011, "R4", "gap filled, both retire", arf_we, 3'b011);
      resume();

      // R6/R7/R8/R9/R10: deferred fault behind unfinished entries
      for (int k = 0; k < 5; k++) begin
         alloc_one(k == 1, 12 + k, 32'h4000 + 32'(4*k));
         a[k] = last_tag;
      end
      wb_one(a[2], 32'hD2, 1);
      peek();
      check(flush == 1'b0, "R6", "fault not raised at writeback", flush, 0);
      resume();
      wb_one(a[3], 32'hD3, 1);
      wb_one(a[4], 32'hD4, 0);
      wb_one(a[1], 32'hD1, 0);
      peek();
      check(flush == 1'b0, "R6", "fault waits for older entry", flush, 0);
      resume();
      wb_one(a[0], 32'hD0, 0);
      expect_retire(0, a[0]); expect_retire(1, a[1]); expect_trap(a[2]);
      peek();
      check(flush == 1'b1, "R7", "flush at retirement", flush, 1);
      check(arf_we == 3'b001 && st_release == 3'b010, "R8", "older retire, faulted not",
            {arf_we, st_release}, {3'b001, 3'b010});
      check(alloc_ready == 1'b0, "R9", "no alloc in flush cycle", alloc_ready, 0);
      resume();
      exp_tail = exp_head;
      peek();
      check(flush == 1'b0, "R10", "younger fault never raised", flush, 0);
      check(arf_we == '0 && st_release == '0, "R8", "flushed entries silent", {arf_we, st_release}, 0);
      check(alloc_ready == 1'b1, "R9", "ready after flush", alloc_ready, 1);
      check(int'(alloc_tag) == exp_tail % DEPTH, "R9", "tag after flush", alloc_tag, exp_tail % DEPTH);
      resume();

      // R8: fault at the head with a finished younger entry
      alloc_one(0, 20, 32'h5000); t0 = last_tag;
      alloc_one(0, 21, 32'h5004); t1 = last_tag;
      wb_one(t1, 32'hE1, 0);
      wb_one(t0, 32'hE0, 1);
      expect_trap(t0);
      peek();
      check(flush == 1'b1, "R7", "head fault flush", flush, 1);
      check(arf_we == 3'b000, "R8", "nothing retires with head fault", arf_we, 0);
      resume();
      exp_tail = exp_head;

      // R2: fill to capacity, refused request leaves tags unchanged
      for (int k = 0; k < DEPTH; k++) begin
         alloc_one(0, k + 1, 32'h6000 + 32'(4*k));
         f[k] = last_tag;
      end
      peek();
      check(alloc_ready == 1'b0, "R2", "full stalls allocation", alloc_ready, 0);
      resume();
      alloc_valid = 1'b1; alloc_dest = 5'd30; alloc_pc = 32'h7000;
      resume();
      alloc_valid = 1'b0;
      for (int k = DEPTH-1; k >= 0; k--) wb_one(f[k], 32'hF0 + 32'(k), 0);
      for (int k = 0; k < DEPTH; k++) expect_retire(k % 3, f[k]);
      repeat (5) resume();
      peek();
      check(int'(alloc_tag) == exp_head % DEPTH, "R2", "refused alloc left no trace",
            alloc_tag, exp_head % DEPTH);
      check(exp_q.size() == 0, "R3", "all expected retirements seen", exp_q.size(), 0);
      check(flush_q.size() == 0, "R10", "all expected flushes seen", flush_q.size(), 0);
      done_flag = 1'b1;
      report();
   end

endmodule